// File: doc/BRIEF.md
# Byte-wide serial master with status flags

This block is an 8-bit synchronous serial master with a clock and data pin, a data-out pin and a data-in pin. It supports all four combinations of clock polarity and clock phase. Software writes a byte into a one-deep transmit holding register. The block moves that byte into a shift register and clocks it out most significant bit first, while it shifts in the byte on the data-in pin. Each received byte is copied into a receive holding register. The serial bit clock runs at half the system clock rate, so one system clock cycle is one half bit.

Four status flags give the exact state of the link. The first shows that the transmit register is empty. The second shows that a received byte is waiting. The third is a one-cycle strobe that marks the end of a byte transfer. The fourth shows that a new byte overwrote one that had not yet been read. One interrupt output reports either the transmit-empty condition or the end-of-transfer strobe. The transmit-empty interrupt stays silent after enable until the first written byte has entered the shifter.

The flag timing depends on the mode. With clock phase 0, the end-of-transfer strobe comes one half bit after the receive-full flag rises. With clock phase 1, the two appear together. Overrun is always flagged one half bit before the capture that causes it.

Top module: `spi_master_stat`

## Requirements
- R1: While no byte is in flight, `sclk` holds the level of `cpol`. A byte takes 8 bit periods of 2 `clk` cycles each (16 cycles in total), and `mosi` carries the transmit byte most significant bit first.
- R2: With `cpha`=0, data is sampled on the leading `sclk` edge (the edge away from the idle level) and changes on the trailing edge. With `cpha`=1, data changes on the leading edge and is sampled on the trailing edge. The received byte is assembled most significant bit first and shown on `rx_data`.
- R3: `tx_empty` is 0 while `en` is 0. It is 1 from the cycle after `en` rises. It reads 0 in the cycle after a `tx_wr` strobe.
- R4: If the shifter is idle when a byte is written, the byte is loaded into the shifter one cycle after the write is registered. `tx_empty` then reads 1 again, 2 cycles after the `tx_wr` strobe.
- R5: `rx_full` rises in the cycle after the edge that samples the eighth bit. For the first byte after an idle write, that is 17 cycles after `tx_wr` for `cpha`=0 and 18 for `cpha`=1. `rx_full` stays set until an `rx_rd` strobe, which clears it in the next cycle.
- R6: `xfer_done` is high for exactly one cycle, 18 cycles after the write. This is one cycle after `rx_full` for `cpha`=0 and the same cycle as `rx_full` for `cpha`=1.
- R7: If `rx_full` is still set one half bit before the eighth sampling edge, `overrun` sets one cycle before `rx_full` would rise. The new byte overwrites `rx_data`. `overrun` stays set until `rx_rd` clears it together with `rx_full`.
- R8: With `irq_sel`=0, `irq` equals `tx_empty`, but only after a byte has been loaded into the shifter since the last enable. With `irq_sel`=1, `irq` equals `xfer_done`.
- R9: If a byte is waiting in the transmit register when a transfer ends, the next transfer starts with no idle half bit. The second byte's receive capture comes exactly 16 cycles after the first.
- R10: Dropping `en` aborts any transfer. In the next cycle `sclk` returns to `cpol`, all four flags are 0, and the transmit-empty interrupt is disarmed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial bit rate is half of it |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low aborts and clears |
| cpol | input | 1 | Idle level of `sclk` |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| irq_sel | input | 1 | 0: interrupt on transmit empty, 1: interrupt on transfer end |
| tx_wr | input | 1 | Write strobe for the transmit register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read strobe for the receive register |
| rx_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit register can take a byte |
| rx_full | output | 1 | A received byte is waiting |
| xfer_done | output | 1 | One-cycle end-of-transfer strobe |
| overrun | output | 1 | An unread byte was overwritten |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Each flag has a known number of cycles from the `tx_wr` strobe to its change: 1 for `tx_empty` falling and 2 for it rising again, 17 or 18 for `rx_full`, 16 or 17 for `overrun` depending on `cpha`, and 18 for `xfer_done`. The bench counts rising clock edges from the write and reads each flag in the cycle before and the cycle of its expected change. A bench-side slave drives `miso` the moment `sclk` moves. A separate monitor rebuilds the `mosi` byte from the values held just before each sampling edge. This checks bit order and edge choice without looking inside the design.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // a half-bit phase is a sampling phase when its parity matches the clock phase
    function automatic logic is_sample_phase(input logic cpha, input logic ph_lsb);
        return cpha ? ph_lsb : ~ph_lsb;
    endfunction

    // level sclk takes at the end of a running phase
    function automatic logic sclk_after(input logic cpol, input logic ph_lsb);
        return cpol ^ ~ph_lsb;
    endfunction

endpackage

// File: rtl/spim_seq.sv
module spim_seq #(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cpol,
    input  logic cpha,
    input  logic tx_pending,
    output logic sclk,
    output logic ev_load,
    output logic ev_shift,
    output logic ev_sample,
    output logic ev_sample_last,
    output logic ev_pre_last,
    output logic ev_last_phase
);
    import spim_pkg::*;

    localparam int PHASES = 2 * DATA_W;
    localparam int PH_W   = $clog2(PHASES);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PHASES - 1);
    localparam logic [PH_W-1:0] PH_LAST1 = PH_W'(PHASES - 2);
    localparam logic [PH_W-1:0] PH_LAST2 = PH_W'(PHASES - 3);

    seq_state_e      state_q;
    logic [PH_W-1:0] ph_q;
    logic            running;
    logic            at_last;

    assign running        = en && (state_q == SEQ_RUN);
    assign at_last        = running && (ph_q == PH_LAST);
    assign ev_last_phase  = at_last;
    assign ev_load        = en && tx_pending && ((state_q == SEQ_IDLE) || at_last);
    assign ev_sample      = running && is_sample_phase(cpha, ph_q[0]);
    assign ev_sample_last = running && (ph_q == (cpha ? PH_LAST : PH_LAST1));
    assign ev_pre_last    = running && (ph_q == (cpha ? PH_LAST1 : PH_LAST2));

    always_comb begin
        if (cpha)
            ev_shift = running && !ph_q[0] && (ph_q != '0);
        else
            ev_shift = running && ph_q[0] && (ph_q != PH_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= SEQ_IDLE;
            ph_q    <= '0;
        end else if (ev_load) begin
            state_q <= SEQ_RUN;
            ph_q    <= '0;
        end else if (at_last) begin
            state_q <= SEQ_IDLE;
            ph_q    <= '0;
        end else if (running) begin
            ph_q    <= ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en || !running)
            sclk <= cpol;
        else
            sclk <= sclk_after(cpol, ph_q[0]);
    end

endmodule

// File: rtl/spim_txpath.sv
module spim_txpath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ev_load,
    input  logic              ev_shift,
    output logic              tx_pending,
    output logic              armed,
    output logic              mosi
);
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] shreg_q;
    logic              full_q;

    assign tx_pending = full_q;
    assign mosi       = shreg_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            full_q <= 1'b0;
        end else if (tx_wr) begin
            full_q <= 1'b1;
        end else if (ev_load) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (en && tx_wr)
            hold_q <= tx_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shreg_q <= '0;
        else if (ev_load)
            shreg_q <= hold_q;
        else if (ev_shift)
            shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            armed <= 1'b0;
        else if (ev_load)
            armed <= 1'b1;
    end

endmodule

// File: rtl/spim_rxpath.sv
module spim_rxpath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              miso,
    input  logic              rx_rd,
    input  logic              ev_sample,
    input  logic              ev_sample_last,
    input  logic              ev_pre_last,
    input  logic              ev_last_phase,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              xfer_done
);
    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] next_byte;

    assign next_byte = {shreg_q[DATA_W-2:0], miso};

    always_ff @(posedge clk) begin
        if (rst)
            shreg_q <= '0;
        else if (ev_sample)
            shreg_q <= next_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_data <= '0;
        else if (ev_sample_last)
            rx_data <= next_byte;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            rx_full <= 1'b0;
        else if (ev_sample_last)
            rx_full <= 1'b1;
        else if (rx_rd)
            rx_full <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            overrun <= 1'b0;
        else if (ev_pre_last && rx_full && !rx_rd)
            overrun <= 1'b1;
        else if (rx_rd)
            overrun <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            xfer_done <= 1'b0;
        else
            xfer_done <= ev_last_phase;
    end

endmodule

// File: rtl/spi_master_stat.sv
module spi_master_stat #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              irq_sel,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              xfer_done,
    output logic              overrun,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic ev_load, ev_shift, ev_sample, ev_sample_last, ev_pre_last, ev_last_phase;
    logic tx_pending, armed;

    spim_seq #(.DATA_W(DATA_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .cpol           (cpol),
        .cpha           (cpha),
        .tx_pending     (tx_pending),
        .sclk           (sclk),
        .ev_load        (ev_load),
        .ev_shift       (ev_shift),
        .ev_sample      (ev_sample),
        .ev_sample_last (ev_sample_last),
        .ev_pre_last    (ev_pre_last),
        .ev_last_phase  (ev_last_phase)
    );

    spim_txpath #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .ev_load    (ev_load),
        .ev_shift   (ev_shift),
        .tx_pending (tx_pending),
        .armed      (armed),
        .mosi       (mosi)
    );

    spim_rxpath #(.DATA_W(DATA_W)) u_rx (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .miso           (miso),
        .rx_rd          (rx_rd),
        .ev_sample      (ev_sample),
        .ev_sample_last (ev_sample_last),
        .ev_pre_last    (ev_pre_last),
        .ev_last_phase  (ev_last_phase),
        .rx_data        (rx_data),
        .rx_full        (rx_full),
        .overrun        (overrun),
        .xfer_done      (xfer_done)
    );

    assign tx_empty = en && !tx_pending;
    assign irq      = irq_sel ? xfer_done : (tx_empty && armed);

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic cpol,
    input logic tx_wr,
    input logic rx_rd,
    input logic irq_sel,
    input logic tx_empty,
    input logic rx_full,
    input logic overrun,
    input logic xfer_done,
    input logic irq,
    input logic sclk
);
    a_r3_written_not_empty: assert property (@(posedge clk) disable iff (rst)
        (en && tx_wr) |=> !tx_empty);

    a_r5_full_holds: assert property (@(posedge clk) disable iff (rst)
        (en && rx_full && !rx_rd) |=> rx_full);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !xfer_done);

    a_r7_overrun_needs_full: assert property (@(posedge clk) disable iff (rst)
        overrun |-> rx_full);

    a_r8_irq_done_src: assert property (@(posedge clk) disable iff (rst)
        (irq_sel && irq) |-> xfer_done);

    a_r8_irq_empty_src: assert property (@(posedge clk) disable iff (rst)
        (!irq_sel && irq) |-> tx_empty);

    a_r10_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!rx_full && !overrun && !xfer_done && sclk == $past(cpol)));

endmodule

bind spi_master_stat spim_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cpol      (cpol),
    .tx_wr     (tx_wr),
    .rx_rd     (rx_rd),
    .irq_sel   (irq_sel),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .xfer_done (xfer_done),
    .irq       (irq),
    .sclk      (sclk)
);

// File: tb/spi_master_stat_bench.sv
module spi_master_stat_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {cpol, cpha, tx byte, slave byte}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 8'h81, 8'h7E},
        {1'b1, 1'b0, 8'h5A, 8'hC3},
        {1'b1, 1'b1, 8'h01, 8'h80},
        {1'b0, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b1, 8'h96, 8'hE7}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       irq_sel = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_rd = 1'b0;
    logic       miso = 1'b0;
    logic [7:0] rx_data;
    logic       tx_empty, rx_full, xfer_done, overrun, irq, sclk, mosi;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cnt = 0;
    bit  finished = 1'b0;

    logic [15:0] sword = '0;
    int          sidx = 15;
    logic        sl_active = 1'b0;
    logic        sl_lead;
    logic [15:0] mon = '0;
    logic        m_prev_sclk = 1'b0;
    logic        m_prev_mosi = 1'b0;
    logic        m_lead;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_master_stat u_spi_master_stat (
        .clk(clk), .rst(rst), .en(en), .cpol(cpol), .cpha(cpha), .irq_sel(irq_sel),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .xfer_done(xfer_done),
        .overrun(overrun), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // slave: changes miso on the non-sampling edge, right when sclk moves
    always @(sclk) begin
        if (sl_active) begin
            sl_lead = (sclk != cpol);
            if (cpha && sl_lead) begin
                if (sidx >= 0) miso = sword[sidx];
                sidx = sidx - 1;
            end else if (!cpha && !sl_lead) begin
                sidx = sidx - 1;
                if (sidx >= 0) miso = sword[sidx];
            end
        end
    end

    // monitor: rebuilds mosi from the value held just before each sampling edge
    always @(posedge clk) begin
        if (en && sclk !== m_prev_sclk) begin
            m_lead = (sclk != cpol);
            if (cpha ? !m_lead : m_lead) mon = {mon[14:0], m_prev_mosi};
        end
        m_prev_sclk = sclk;
        m_prev_mosi = mosi;
    end

    task automatic tick();
        @(posedge clk);
        #2;
        cnt++;
    endtask

    task automatic wait_to(input int n);
        while (cnt < n) tick();
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cnt);
        end
    endtask

    // sets the mode, prepares the slave, writes a byte; returns with cnt = 1
    task automatic start_xfer(input logic p, input logic h, input logic [7:0] b,
                              input logic [15:0] sw);
        sl_active = 1'b0;
        cpol = p;
        cpha = h;
        repeat (3) tick();
        mon = '0;
        sword = sw;
        sidx = 15;
        if (!h) miso = sw[15];
        sl_active = 1'b1;
        tx_data = b;
        tx_wr = 1'b1;
        cnt = 0;
        tick();
        tx_wr = 1'b0;
    endtask

    task automatic read_rx();
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // reset state, disabled
        repeat (2) tick();
        rst = 1'b0;
        tick();
        chk("R3 empty while disabled", {15'd0, tx_empty}, 16'd0);
        chk("R10 idle flags", {12'd0, rx_full, overrun, xfer_done, irq}, 16'd0);
        chk("R1 idle sclk", {15'd0, sclk}, 16'd0);
        en = 1'b1;
        tick();
        chk("R3 empty on enable", {15'd0, tx_empty}, 16'd1);
        chk("R8 no irq on enable", {15'd0, irq}, 16'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic p, h;
            logic [7:0] tb_, sb;
            int full_at;
            {p, h, tb_, sb} = VEC[i];
            full_at = h ? 18 : 17;
            start_xfer(p, h, tb_, {sb, 8'h00});
            chk("R3 empty clears after write", {15'd0, tx_empty}, 16'd0);
            tick();
            chk("R4 loaded, empty again", {15'd0, tx_empty}, 16'd1);
            chk("R8 irq after first load", {15'd0, irq}, 16'd1);
            wait_to(full_at - 1);
            chk("R5 full not yet", {15'd0, rx_full}, 16'd0);
            tick();
            chk("R5 full on eighth sample", {15'd0, rx_full}, 16'd1);
            if (!h) begin
                chk("R6 done lags full", {15'd0, xfer_done}, 16'd0);
                tick();
            end
            chk("R6 done strobe", {15'd0, xfer_done}, 16'd1);
            tick();
            chk("R6 done single cycle", {15'd0, xfer_done}, 16'd0);
            wait_to(20);
            chk("R1 mosi msb first", {8'd0, mon[7:0]}, {8'd0, tb_});
            chk("R2 rx byte", {8'd0, rx_data}, {8'd0, sb});
            chk("R7 no overrun", {15'd0, overrun}, 16'd0);
            chk("R1 sclk back idle", {15'd0, sclk}, {15'd0, p});
            read_rx();
            chk("R5 read clears full", {15'd0, rx_full}, 16'd0);
        end

        // overrun, mode 1 then mode 0
        for (int m = 0; m < 2; m++) begin
            logic h;
            int ov_at;
            h = (m == 0);
            ov_at = h ? 17 : 16;
            start_xfer(1'b0, h, 8'h11, {8'h22, 8'h00});
            wait_to(20);
            start_xfer(1'b0, h, 8'h33, {8'h44, 8'h00});
            wait_to(ov_at - 1);
            chk("R7 overrun not yet", {15'd0, overrun}, 16'd0);
            tick();
            chk("R7 overrun half bit early", {15'd0, overrun}, 16'd1);
            chk("R7 old byte still held", {8'd0, rx_data}, 16'h0022);
            wait_to(20);
            chk("R7 new byte overwrites", {8'd0, rx_data}, 16'h0044);
            chk("R7 overrun sticky", {15'd0, overrun}, 16'd1);
            read_rx();
            chk("R7 read clears overrun", {14'd0, overrun, rx_full}, 16'd0);
        end

        // interrupt on transfer end
        irq_sel = 1'b1;
        start_xfer(1'b0, 1'b0, 8'h5C, {8'h9D, 8'h00});
        wait_to(17);
        chk("R8 done irq not yet", {15'd0, irq}, 16'd0);
        tick();
        chk("R8 done irq", {15'd0, irq}, 16'd1);
        tick();
        chk("R8 done irq drops", {15'd0, irq}, 16'd0);
        read_rx();
        irq_sel = 1'b0;

        // back-to-back
        start_xfer(1'b0, 1'b0, 8'hC6, {8'h3A, 8'h5B});
        wait_to(3);
        tx_data = 8'h6D;
        tx_wr = 1'b1;
        tick();
        tx_wr = 1'b0;
        chk("R9 second byte held", {15'd0, tx_empty}, 16'd0);
        wait_to(17);
        chk("R9 still held at end", {15'd0, tx_empty}, 16'd0);
        tick();
        chk("R9 reload at end", {15'd0, tx_empty}, 16'd1);
        wait_to(20);
        read_rx();
        wait_to(32);
        chk("R9 second full not yet", {15'd0, rx_full}, 16'd0);
        tick();
        chk("R9 second full 16 later", {15'd0, rx_full}, 16'd1);
        chk("R9 second rx byte", {8'd0, rx_data}, 16'h005B);
        wait_to(36);
        chk("R9 mosi stream", mon, 16'hC66D);
        read_rx();

        // abort by disable, mode 3
        start_xfer(1'b1, 1'b1, 8'hF0, {8'h0F, 8'h00});
        wait_to(8);
        chk("R8 irq armed mid transfer", {15'd0, irq}, 16'd1);
        en = 1'b0;
        tick();
        sl_active = 1'b0;
        chk("R10 sclk idle on disable", {15'd0, sclk}, 16'd1);
        chk("R10 flags cleared", {12'd0, tx_empty, rx_full, overrun, xfer_done}, 16'd0);
        en = 1'b1;
        tick();
        chk("R3 empty after re-enable", {15'd0, tx_empty}, 16'd1);
        chk("R10 irq disarmed", {15'd0, irq}, 16'd0);
        repeat (20) tick();
        chk("R10 no capture after abort", {15'd0, rx_full}, 16'd0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule